// File: doc/BRIEF.md
# One-Second Reference Generator

This block divides one of fifteen reference tick streams down to a one-hertz square wave for timing performance-monitor intervals. All logic runs on one system clock. Each source arrives as a single-cycle tick that is already synchronized, one tick per cycle of the source clock. A 4-bit select code chooses the source. Three line-rate references use fixed divisors set by parameters. Twelve per-port transmit clocks share a programmable divisor input.

Each rising edge of the square wave sets a sticky status flag. The flag can drive an interrupt, and software clears it by writing 1. The rising edge also issues a one-cycle update strobe to the performance counters when the upper bit of the 2-bit PM mode is set. A gated copy of the square wave goes to a pin output. All outputs are registered.

Top module: `one_sec_ref_gen`

## Requirements
- R1: `sq_o` is a divided square wave. For an effective divisor N, it stays high for floor(N/2) ticks of the selected source and low for the remaining N - floor(N/2) ticks. It starts in its low half, and ticks on unselected sources have no effect.
- R2: The select code maps to sources as follows. Code 0 is off. Code 1 is the DS3 reference (`src_tick_i` bit 0, divisor DS3_DIV). Code 2 is the E3 reference (bit 1, E3_DIV). Code 3 is the STS-1 reference (bit 2, STS_DIV). Codes 4 to 15 are ports 1 to 12 (bits 3 to 14), which use `port_div_i`. A divisor below 2 is treated as 2.
- R3: While the select code is 0, `sq_o` and `pin_o` stay low and no status, interrupt or strobe event occurs.
- R4: The cycle in which `sq_o` goes from 0 to 1 also sets `stat_o`. `stat_o` then stays at 1 until it is cleared.
- R5: `irq_o` equals `stat_o` gated by `irq_en_i` as sampled at the previous edge.
- R6: `pm_upd_o` pulses high for exactly the one cycle in which `sq_o` rises, and only when `pm_mode_i[1]` was 1 at that edge.
- R7: `pin_o` equals `sq_o` when `pin_oe_i` was 1 at the edge, and is 0 otherwise.
- R8: After an edge at which the select code differs from its previous value, `sq_o` is low and the tick count restarts. The first rise then follows a full low half.
- R9: At an edge where `stat_clr_i` is 1, `stat_o` is cleared. If a rise occurs at the same edge, the set wins and `stat_o` stays at 1.
- R10: While `rst` is high at an edge, all outputs go low and the stored select code returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick_i | input | 15 | Synchronized source ticks; bits 0-2 line references, 3-14 ports 1-12 |
| sel_i | input | 4 | Source select code |
| port_div_i | input | 27 | Ticks per second for port sources |
| pm_mode_i | input | 2 | PM update mode; bit 1 enables the strobe |
| irq_en_i | input | 1 | Interrupt enable |
| pin_oe_i | input | 1 | Pin output enable |
| stat_clr_i | input | 1 | Write-1-to-clear for the status flag |
| sq_o | output | 1 | One-second square wave |
| stat_o | output | 1 | Sticky rising-edge status |
| irq_o | output | 1 | Interrupt request |
| pm_upd_o | output | 1 | One-cycle PM update strobe |
| pin_o | output | 1 | Gated square wave for the pin |

## Verification
The hardest case to reach from the ports is a clear that lands on the exact edge where the wave rises. The bench reaches it by holding `stat_clr_i` high across several full periods with the E3 source ticking every cycle. Under that stimulus the status flag must be high exactly in the strobe cycles, so the two counts must match. A behavioural model also predicts every output on every clock through random sparse ticks, select changes and a clamped port divisor. It catches any off-by-one in the split between the high and low halves.

// File: rtl/osr_pkg.sv
package osr_pkg;
  localparam int OSR_NUM_LINE = 3;
  localparam int OSR_SEL_OFF  = 0;

  typedef struct packed {
    logic rise;
    logic level;
  } osr_wave_t;
endpackage

// File: rtl/osr_src_mux.sv
module osr_src_mux #(
  parameter int NUM_PORTS = 12,
  parameter int DIV_W     = 27,
  parameter int DS3_DIV   = 44736000,
  parameter int E3_DIV    = 34368000,
  parameter int STS_DIV   = 51840000,
  localparam int NUM_SRC  = osr_pkg::OSR_NUM_LINE + NUM_PORTS,
  localparam int SEL_W    = $clog2(NUM_SRC + 1)
) (
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [NUM_SRC-1:0] src_tick_i,
  input  logic [DIV_W-1:0]   port_div_i,
  output logic               tick_o,
  output logic [DIV_W-1:0]   div_o
);
  logic [DIV_W-1:0] div_tab [NUM_SRC];
  logic [DIV_W-1:0] div_raw;
  logic [SEL_W-1:0] idx;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_div
    if (g == 0) begin : g_ds3
      assign div_tab[g] = DIV_W'(DS3_DIV);
    end else if (g == 1) begin : g_e3
      assign div_tab[g] = DIV_W'(E3_DIV);
    end else if (g == 2) begin : g_sts
      assign div_tab[g] = DIV_W'(STS_DIV);
    end else begin : g_port
      assign div_tab[g] = port_div_i;
    end
  end

  assign idx = sel_i - SEL_W'(1);

  always_comb begin
    tick_o  = 1'b0;
    div_raw = DIV_W'(2);
    if (sel_i != SEL_W'(osr_pkg::OSR_SEL_OFF) && int'(sel_i) <= NUM_SRC) begin
      tick_o  = src_tick_i[idx];
      div_raw = div_tab[idx];
    end
  end

  assign div_o = (div_raw < DIV_W'(2)) ? DIV_W'(2) : div_raw;
endmodule

// File: rtl/osr_divider.sv
module osr_divider #(
  parameter int DIV_W = 27,
  parameter int SEL_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic                tick_i,
  input  logic [DIV_W-1:0]    div_i,
  output osr_pkg::osr_wave_t  nxt_o,
  output logic                sq_o
);
  logic [SEL_W-1:0] sel_q;
  logic [DIV_W-1:0] cnt_q, cnt_d, hi_len, lo_len, need;
  logic             sq_q, sq_d;

  assign hi_len = div_i >> 1;
  assign lo_len = div_i - hi_len;
  assign need   = sq_q ? hi_len : lo_len;

  always_comb begin
    cnt_d = cnt_q;
    sq_d  = sq_q;
    if (sel_i == SEL_W'(osr_pkg::OSR_SEL_OFF) || sel_i != sel_q) begin
      cnt_d = '0;
      sq_d  = 1'b0;
    end else if (tick_i) begin
      if (cnt_q >= need - DIV_W'(1)) begin
        cnt_d = '0;
        sq_d  = ~sq_q;
      end else begin
        cnt_d = cnt_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      cnt_q <= '0;
      sq_q  <= 1'b0;
    end else begin
      sel_q <= sel_i;
      cnt_q <= cnt_d;
      sq_q  <= sq_d;
    end
  end

  assign nxt_o.rise  = sq_d & ~sq_q;
  assign nxt_o.level = sq_d;
  assign sq_o        = sq_q;

  // R3
  off_low_chk: assert property (@(posedge clk) disable iff (rst)
    sel_i == SEL_W'(0) |=> !sq_q);
  // R8
  sel_change_low_chk: assert property (@(posedge clk) disable iff (rst)
    sel_i != sel_q |=> !sq_q);
  // R1
  rise_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sq_q) |-> $past(tick_i));
endmodule

// File: rtl/osr_event.sv
module osr_event (
  input  logic               clk,
  input  logic               rst,
  input  osr_pkg::osr_wave_t nxt_i,
  input  logic [1:0]         pm_mode_i,
  input  logic               irq_en_i,
  input  logic               pin_oe_i,
  input  logic               stat_clr_i,
  output logic               stat_o,
  output logic               irq_o,
  output logic               pm_upd_o,
  output logic               pin_o
);
  logic stat_d;

  assign stat_d = nxt_i.rise | (stat_o & ~stat_clr_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_o   <= 1'b0;
      irq_o    <= 1'b0;
      pm_upd_o <= 1'b0;
      pin_o    <= 1'b0;
    end else begin
      stat_o   <= stat_d;
      irq_o    <= irq_en_i & stat_d;
      pm_upd_o <= nxt_i.rise & pm_mode_i[1];
      pin_o    <= pin_oe_i & nxt_i.level;
    end
  end

  // R4
  stat_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    stat_o && !stat_clr_i |=> stat_o);
  // R6
  pm_mode_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !pm_mode_i[1] |=> !pm_upd_o);
  // R7
  pin_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !pin_oe_i |=> !pin_o);
  // R5
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_en_i |=> !irq_o);
endmodule

// File: rtl/one_sec_ref_gen.sv
module one_sec_ref_gen #(
  parameter int NUM_PORTS = 12,
  parameter int DIV_W     = 27,
  parameter int DS3_DIV   = 44736000,
  parameter int E3_DIV    = 34368000,
  parameter int STS_DIV   = 51840000,
  localparam int NUM_SRC  = osr_pkg::OSR_NUM_LINE + NUM_PORTS,
  localparam int SEL_W    = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_tick_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [DIV_W-1:0]   port_div_i,
  input  logic [1:0]         pm_mode_i,
  input  logic               irq_en_i,
  input  logic               pin_oe_i,
  input  logic               stat_clr_i,
  output logic               sq_o,
  output logic               stat_o,
  output logic               irq_o,
  output logic               pm_upd_o,
  output logic               pin_o
);
  logic               tick;
  logic [DIV_W-1:0]   div_eff;
  osr_pkg::osr_wave_t wave_nxt;

  osr_src_mux #(
    .NUM_PORTS(NUM_PORTS), .DIV_W(DIV_W),
    .DS3_DIV(DS3_DIV), .E3_DIV(E3_DIV), .STS_DIV(STS_DIV)
  ) u_mux (
    .sel_i(sel_i), .src_tick_i(src_tick_i), .port_div_i(port_div_i),
    .tick_o(tick), .div_o(div_eff)
  );

  osr_divider #(.DIV_W(DIV_W), .SEL_W(SEL_W)) u_div (
    .clk(clk), .rst(rst), .sel_i(sel_i), .tick_i(tick), .div_i(div_eff),
    .nxt_o(wave_nxt), .sq_o(sq_o)
  );

  osr_event u_evt (
    .clk(clk), .rst(rst), .nxt_i(wave_nxt), .pm_mode_i(pm_mode_i),
    .irq_en_i(irq_en_i), .pin_oe_i(pin_oe_i), .stat_clr_i(stat_clr_i),
    .stat_o(stat_o), .irq_o(irq_o), .pm_upd_o(pm_upd_o), .pin_o(pin_o)
  );

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !sq_o && !stat_o && !irq_o && !pm_upd_o && !pin_o);
endmodule

// File: tb/one_sec_ref_gen_tb.sv
module one_sec_ref_gen_tb;
  localparam int DS3_N = 10, E3_N = 7, STS_N = 12;

  logic        clk = 1'b0, rst = 1'b1;
  logic [14:0] src_tick = '0;
  logic [3:0]  sel = '0;
  logic [26:0] port_div = 27'd7;
  logic [1:0]  pm_mode = 2'b10;
  logic        irq_en = 1'b1, pin_oe = 1'b1, stat_clr = 1'b0;
  logic        sq, stat, irq, pm, pin;
  int          tick_mode = 0;
  int          checks = 0, failures = 0, cyc = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  one_sec_ref_gen #(.DS3_DIV(DS3_N), .E3_DIV(E3_N), .STS_DIV(STS_N)) u_dut (
    .clk(clk), .rst(rst), .src_tick_i(src_tick), .sel_i(sel),
    .port_div_i(port_div), .pm_mode_i(pm_mode), .irq_en_i(irq_en),
    .pin_oe_i(pin_oe), .stat_clr_i(stat_clr), .sq_o(sq), .stat_o(stat),
    .irq_o(irq), .pm_upd_o(pm), .pin_o(pin)
  );

  // behavioural reference model
  int m_prev = 0, m_done = 0;
  bit m_sq = 0, m_stat = 0, m_irq = 0, m_pm = 0, m_pin = 0;

  function automatic int eff_div(int s);
    int n;
    if (s == 1) n = DS3_N; else if (s == 2) n = E3_N;
    else if (s == 3) n = STS_N; else n = int'(port_div);
    return (n < 2) ? 2 : n;
  endfunction

  always @(posedge clk) begin
    bit rise;
    int n, need;
    rise = 0;
    if (rst) begin
      m_prev = 0; m_done = 0; m_sq = 0; m_stat = 0; m_irq = 0; m_pm = 0; m_pin = 0;
    end else begin
      if (sel == 0 || int'(sel) != m_prev) begin
        m_sq = 0; m_done = 0;
      end else if (src_tick[sel - 1]) begin
        n = eff_div(int'(sel));
        need = m_sq ? n / 2 : n - n / 2;
        m_done++;
        if (m_done >= need) begin
          m_sq = !m_sq; m_done = 0; rise = m_sq;
        end
      end
      m_prev = int'(sel);
      m_stat = rise | (m_stat & !stat_clr);
      m_irq  = irq_en & m_stat;
      m_pm   = rise & pm_mode[1];
      m_pin  = pin_oe & m_sq;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R1 sq_o model", sq, m_sq);
      chk("R4 stat_o model", stat, m_stat);
      chk("R5 irq_o model", irq, m_irq);
      chk("R6 pm_upd_o model", pm, m_pm);
      chk("R7 pin_o model", pin, m_pin);
    end
  end

  always @(negedge clk) begin
    if (tick_mode == 0) src_tick <= '1;
    else src_tick <= 15'($urandom);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic run_count(int n, output int pmc, output int sqc, output int stc, output int pinc);
    pmc = 0; sqc = 0; stc = 0; pinc = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pmc += int'(pm); sqc += int'(sq); stc += int'(stat); pinc += int'(pin);
    end
  endtask

  task automatic measure(output int hi, output int lo);
    hi = 0; lo = 0;
    do @(negedge clk); while (sq);
    do @(negedge clk); while (!sq);
    while (sq) begin hi++; @(negedge clk); end
    while (!sq) begin lo++; @(negedge clk); end
  endtask

  initial begin
    int pmc, sqc, stc, pinc, hi, lo;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10 reset outputs", {sq, stat, irq, pm, pin}, 0);
    rst = 1'b0;

    // R2 DS3 divisor: ticks every cycle, 10 rises in 103 cycles
    sel = 4'd1;
    run_count(103, pmc, sqc, stc, pinc);
    chk("R2 DS3 rise count", pmc, 10);

    // R1 odd port divisor, sparse then dense ticks (port 2 = bit 4)
    port_div = 27'd7; sel = 4'd5; tick_mode = 1;
    run_count(300, pmc, sqc, stc, pinc);
    tick_mode = 0;
    measure(hi, lo);
    chk("R1 high half N=7", hi, 3);
    chk("R1 low half N=7", lo, 4);

    // R3 disabled
    @(negedge clk); sel = 4'd0; stat_clr = 1'b1;
    @(negedge clk); stat_clr = 1'b0;
    run_count(50, pmc, sqc, stc, pinc);
    chk("R3 off sq high cycles", sqc, 0);
    chk("R3 off strobes", pmc, 0);
    chk("R3 off status", stc, 0);

    // R9 clear held high: status only in rise cycles
    sel = 4'd2; stat_clr = 1'b1;
    run_count(60, pmc, sqc, stc, pinc);
    chk("R9 set beats clear", stc, pmc);
    chk("R9 rises seen", int'(pmc > 0), 1);
    stat_clr = 1'b0;

    // R6 strobe masked in mode 01, R4 status still set
    @(negedge clk); pm_mode = 2'b01; sel = 4'd3; stat_clr = 1'b1;
    @(negedge clk); stat_clr = 1'b0;
    run_count(60, pmc, sqc, stc, pinc);
    chk("R6 no strobe in mode 01", pmc, 0);
    chk("R4 status set by rise", int'(stat), 1);

    // R5 interrupt gated by enable
    irq_en = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R5 irq masked", int'(irq), 0);
    irq_en = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R5 irq enabled", int'(irq), 1);

    // R7 pin disabled while wave toggles
    pin_oe = 1'b0; pm_mode = 2'b11;
    @(negedge clk);
    run_count(60, pmc, sqc, stc, pinc);
    chk("R7 pin held low", pinc, 0);
    chk("R7 wave active", int'(sqc > 0), 1);
    pin_oe = 1'b1;

    // R8 select change forces low; R2 clamp of divisor 1 (port 12 = bit 14)
    while (!sq) @(negedge clk);
    port_div = 27'd1; sel = 4'd15;
    @(negedge clk);
    chk("R8 low after select change", int'(sq), 0);
    measure(hi, lo);
    chk("R2 clamp high", hi, 1);
    chk("R2 clamp low", lo, 1);

    repeat (20) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule